// File: doc/BRIEF.md
# Auto-Incrementing Indirect Access Window

This block gives a host a small set of registers through which it reaches internal memory and peripheral registers that are not mapped directly. For memory, the host loads a read pointer or a write pointer and then reads or writes a data register. Each access to a data register issues one request on the internal port and moves that data register's pointer on by one 32-bit word. Streaming a buffer in or out therefore costs one address write followed by one host access per word.

For peripherals, a separate pair of address registers holds a 16-bit register offset and a transfer size. The size is coded as the byte count minus one. Peripheral data accesses do not move their address. Writes drive byte enables only for the low bytes named by the size, and reads return only those bytes.

Every register access needs the access-grant input to be high. An access made without a grant does nothing, except that a read returns all-ones. Either kind of access without a grant latches an error flag that stays set until reset.

Top module: `iaw_window`

## Requirements
- R1: After reset, both memory pointers and both peripheral address registers read back as zero, `host_rvalid` and `acc_err` are low, and `int_req` is low while no host access is made.
- R2: A host write to offset 0x00C loads all 32 bits into the memory read pointer, and a write to offset 0x010 loads all 32 bits into the memory write pointer. Reading either offset returns the pointer's current value.
- R3: A host write to offset 0x018 drives, in the same cycle, `int_req`=1, `int_we`=1, `int_sel_prph`=0, `int_addr` equal to the write pointer, `int_be`=4'b1111 and `int_wdata` equal to the host data. The write pointer then advances by 4.
- R4: A host read of offset 0x01C returns the internal word at the read pointer and then advances the read pointer by 4. The first read after an address load therefore returns the word at the loaded address. The read pointer and the write pointer never affect each other.
- R5: Every host read puts its result on `host_rdata` with `host_rvalid`=1 in the cycle after `host_rd`. `host_rvalid` is 0 in any cycle that does not follow a read.
- R6: The peripheral write-address register (0x044) and read-address register (0x048) keep host data bits 15:0 as the offset and bits 25:24 as the size; all other bits read back as zero. Data accesses at 0x04C (write) and 0x050 (read) drive `int_sel_prph`=1 and `int_addr` equal to the zero-extended offset. These accesses leave the offset unchanged.
- R7: For a peripheral access of size n (0..3), `int_be` has exactly its low n+1 bits set. A peripheral read returns the low n+1 bytes of the internal data, with the upper bytes forced to zero.
- R8: While `acc_grant` is low, a host read returns 32'hFFFFFFFF, a host write changes no register and no memory, and `int_req` stays low. Any such read or write sets `acc_err`, which then stays high until reset.
- R9: With access granted, a read of an offset that is not listed above returns zero, a write to such an offset has no effect, and neither one sets `acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_grant | input | 1 | High when the internal domain may be accessed |
| host_addr | input | 12 | Byte offset of the host access within the window |
| host_wr | input | 1 | Host write strobe (one cycle per access) |
| host_rd | input | 1 | Host read strobe (one cycle per access, never with host_wr) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read result valid, one cycle after host_rd |
| acc_err | output | 1 | Sticky flag: an access was made without a grant |
| int_req | output | 1 | Internal request, one per data access |
| int_we | output | 1 | Internal request is a write |
| int_sel_prph | output | 1 | Internal request targets peripherals (1) or memory (0) |
| int_addr | output | 32 | Internal byte address |
| int_be | output | 4 | Internal byte enables |
| int_wdata | output | 32 | Internal write data |
| int_rdata | input | 32 | Internal read data, returned in the request cycle |

## Verification
The bench first streams words through the write pointer and reads them back through a separately loaded read pointer. It checks that the first read after an address load returns the word at that address, not the next one. If the design incremented before reading, or shared one pointer between reads and writes, the read-back data would be off by one word, and the write-pointer readback would be off as well. The peripheral tests use sizes 0, 1, 2 and 3 against a byte-addressed register model. A wrong byte-enable mask would corrupt the bytes that should be kept, and a peripheral address that moved on would send the repeated read to the next register. Denied accesses are checked at the ports: the read value must be all-ones, the denied write must leave the pointer it aimed at unchanged on readback, and the error flag must stay set. An unmapped offset, by contrast, must leave the flag clear.

// File: rtl/iaw_pkg.sv
package iaw_pkg;
   // Window offsets (bytes); host software decodes these, so they are fixed.
   localparam int OFF_MEM_RPTR  = 'h00C;
   localparam int OFF_MEM_WPTR  = 'h010;
   localparam int OFF_MEM_WDATA = 'h018;
   localparam int OFF_MEM_RDATA = 'h01C;
   localparam int OFF_PRF_WADR  = 'h044;
   localparam int OFF_PRF_RADR  = 'h048;
   localparam int OFF_PRF_WDATA = 'h04C;
   localparam int OFF_PRF_RDATA = 'h050;

   typedef struct packed {
      logic mem_rptr;
      logic mem_wptr;
      logic mem_wdata;
      logic mem_rdata;
      logic prf_wadr;
      logic prf_radr;
      logic prf_wdata;
      logic prf_rdata;
   } iaw_sel_t;
endpackage

// File: rtl/iaw_decode.sv
module iaw_decode
   import iaw_pkg::*;
#(
   parameter int HOST_AW = 12
) (
   input  logic [HOST_AW-1:0] addr,
   output iaw_sel_t           sel
);
   generate
      if (HOST_AW < 8) begin : g_bad_aw
         $error("iaw_decode: HOST_AW must cover offset 0x050");
      end
   endgenerate

   always_comb begin
      sel.mem_rptr  = (addr == HOST_AW'(OFF_MEM_RPTR));
      sel.mem_wptr  = (addr == HOST_AW'(OFF_MEM_WPTR));
      sel.mem_wdata = (addr == HOST_AW'(OFF_MEM_WDATA));
      sel.mem_rdata = (addr == HOST_AW'(OFF_MEM_RDATA));
      sel.prf_wadr  = (addr == HOST_AW'(OFF_PRF_WADR));
      sel.prf_radr  = (addr == HOST_AW'(OFF_PRF_RADR));
      sel.prf_wdata = (addr == HOST_AW'(OFF_PRF_WDATA));
      sel.prf_rdata = (addr == HOST_AW'(OFF_PRF_RDATA));
   end
endmodule

// File: rtl/iaw_ptr.sv
module iaw_ptr #(
   parameter int W        = 32,
   parameter int STEP     = 4,
   parameter bit AUTO_INC = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] q
);
   generate
      if (W < 1 || STEP < 1) begin : g_bad
         $error("iaw_ptr: W and STEP must be positive");
      end
      if (AUTO_INC) begin : g_inc
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= ld_val;
            else if (inc)  q <= q + W'(STEP);
         end
         AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !load) |=> (q == $past(q) + W'(STEP)));  // R4
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= ld_val;
         end
         AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !load) |=> $stable(q));  // R6
      end
   endgenerate

   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(ld_val)));  // R2
endmodule

// File: rtl/iaw_bytemask.sv
module iaw_bytemask #(
   parameter int NB = 4,
   parameter int SW = 2
) (
   input  logic [SW-1:0] cnt_m1,
   output logic [NB-1:0] be,
   output logic [8*NB-1:0] bitmask
);
   generate
      if (NB != (1 << SW)) begin : g_bad
         $error("iaw_bytemask: NB must equal 2**SW");
      end
      for (genvar b = 0; b < NB; b++) begin : g_lane
         assign be[b]            = (cnt_m1 >= SW'(b));
         assign bitmask[8*b +: 8] = {8{be[b]}};
      end
   endgenerate
endmodule

// File: rtl/iaw_window.sv
module iaw_window
   import iaw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int HOST_AW    = 12,
   parameter int PRF_OFF_W  = 16,
   parameter int PRF_SZ_LSB = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_grant,
   input  logic [HOST_AW-1:0]    host_addr,
   input  logic                  host_wr,
   input  logic                  host_rd,
   input  logic [DATA_W-1:0]     host_wdata,
   output logic [DATA_W-1:0]     host_rdata,
   output logic                  host_rvalid,
   output logic                  acc_err,
   output logic                  int_req,
   output logic                  int_we,
   output logic                  int_sel_prph,
   output logic [ADDR_W-1:0]     int_addr,
   output logic [DATA_W/8-1:0]   int_be,
   output logic [DATA_W-1:0]     int_wdata,
   input  logic [DATA_W-1:0]     int_rdata
);
   localparam int NB    = DATA_W / 8;
   localparam int SW    = $clog2(NB);
   localparam int PRF_W = PRF_OFF_W + SW;

   generate
      if (DATA_W % 8 != 0 || NB < 2) begin : g_bad_dw
         $error("iaw_window: DATA_W must be a multiple of 8, at least 16");
      end
      if (ADDR_W > DATA_W || ADDR_W < PRF_OFF_W) begin : g_bad_aw
         $error("iaw_window: ADDR_W must lie between PRF_OFF_W and DATA_W");
      end
      if (PRF_SZ_LSB < PRF_OFF_W || PRF_SZ_LSB + SW > DATA_W) begin : g_bad_sz
         $error("iaw_window: size field must sit above the offset field");
      end
   endgenerate

   iaw_sel_t sel;
   logic wr_ok, rd_ok;
   logic [ADDR_W-1:0] rptr, wptr;
   logic [PRF_W-1:0]  prf_w, prf_r;
   logic [NB-1:0]     be_w, be_r;
   logic [DATA_W-1:0] mask_w, mask_r;
   logic [DATA_W-1:0] rb_prf_w, rb_prf_r, rd_val;

   iaw_decode #(.HOST_AW(HOST_AW)) u_dec (.addr(host_addr), .sel(sel));

   assign wr_ok = host_wr & acc_grant;
   assign rd_ok = host_rd & acc_grant;

   iaw_ptr #(.W(ADDR_W), .STEP(NB), .AUTO_INC(1'b1)) u_rptr (
      .clk(clk), .rst_n(rst_n), .load(wr_ok & sel.mem_rptr),
      .ld_val(host_wdata[ADDR_W-1:0]), .inc(rd_ok & sel.mem_rdata), .q(rptr));

   iaw_ptr #(.W(ADDR_W), .STEP(NB), .AUTO_INC(1'b1)) u_wptr (
      .clk(clk), .rst_n(rst_n), .load(wr_ok & sel.mem_wptr),
      .ld_val(host_wdata[ADDR_W-1:0]), .inc(wr_ok & sel.mem_wdata), .q(wptr));

   iaw_ptr #(.W(PRF_W), .STEP(1), .AUTO_INC(1'b0)) u_prf_w (
      .clk(clk), .rst_n(rst_n), .load(wr_ok & sel.prf_wadr),
      .ld_val({host_wdata[PRF_SZ_LSB +: SW], host_wdata[PRF_OFF_W-1:0]}),
      .inc(wr_ok & sel.prf_wdata), .q(prf_w));

   iaw_ptr #(.W(PRF_W), .STEP(1), .AUTO_INC(1'b0)) u_prf_r (
      .clk(clk), .rst_n(rst_n), .load(wr_ok & sel.prf_radr),
      .ld_val({host_wdata[PRF_SZ_LSB +: SW], host_wdata[PRF_OFF_W-1:0]}),
      .inc(rd_ok & sel.prf_rdata), .q(prf_r));

   iaw_bytemask #(.NB(NB), .SW(SW)) u_bm_w (
      .cnt_m1(prf_w[PRF_W-1 -: SW]), .be(be_w), .bitmask(mask_w));
   iaw_bytemask #(.NB(NB), .SW(SW)) u_bm_r (
      .cnt_m1(prf_r[PRF_W-1 -: SW]), .be(be_r), .bitmask(mask_r));

   // Internal request port
   always_comb begin
      int_req      = (wr_ok & (sel.mem_wdata | sel.prf_wdata)) |
                     (rd_ok & (sel.mem_rdata | sel.prf_rdata));
      int_we       = host_wr;
      int_sel_prph = sel.prf_wdata | sel.prf_rdata;
      int_wdata    = host_wdata;
      if (sel.prf_wdata)      int_addr = ADDR_W'(prf_w[PRF_OFF_W-1:0]);
      else if (sel.prf_rdata) int_addr = ADDR_W'(prf_r[PRF_OFF_W-1:0]);
      else if (host_wr)       int_addr = wptr;
      else                    int_addr = rptr;
      if (sel.prf_wdata)      int_be = be_w;
      else if (sel.prf_rdata) int_be = be_r;
      else                    int_be = '1;
   end

   // Readback of peripheral address registers
   always_comb begin
      rb_prf_w = '0;
      rb_prf_w[PRF_OFF_W-1:0]    = prf_w[PRF_OFF_W-1:0];
      rb_prf_w[PRF_SZ_LSB +: SW] = prf_w[PRF_W-1 -: SW];
      rb_prf_r = '0;
      rb_prf_r[PRF_OFF_W-1:0]    = prf_r[PRF_OFF_W-1:0];
      rb_prf_r[PRF_SZ_LSB +: SW] = prf_r[PRF_W-1 -: SW];
   end

   always_comb begin
      if (!acc_grant)         rd_val = '1;
      else if (sel.mem_rdata) rd_val = int_rdata;
      else if (sel.prf_rdata) rd_val = int_rdata & mask_r;
      else if (sel.mem_rptr)  rd_val = DATA_W'(rptr);
      else if (sel.mem_wptr)  rd_val = DATA_W'(wptr);
      else if (sel.prf_wadr)  rd_val = rb_prf_w;
      else if (sel.prf_radr)  rd_val = rb_prf_r;
      else                    rd_val = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         host_rdata  <= '0;
         acc_err     <= 1'b0;
      end else begin
         host_rvalid <= host_rd;
         if (host_rd) host_rdata <= rd_val;
         if ((host_rd | host_wr) & !acc_grant) acc_err <= 1'b1;
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> acc_err);  // R8
   AST_DENY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_grant |-> !int_req);  // R8
   AST_DENY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !acc_grant) |=> (host_rdata == '1));  // R8
   AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> host_rvalid);  // R5
   AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> !host_rvalid);  // R5
   AST_BE_LOWFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && int_sel_prph) |-> (int_be[0] && ((int_be & (int_be + 1'b1)) == '0)));  // R7
   AST_MEM_FULLBE: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !int_sel_prph) |-> (int_be == '1));  // R3
endmodule

// File: tb/iaw_window_bench.sv
module iaw_window_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_grant = 1'b1;
   logic [11:0] host_addr = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_rvalid;
   logic        acc_err;
   logic        int_req, int_we, int_sel_prph;
   logic [31:0] int_addr;
   logic [3:0]  int_be;
   logic [31:0] int_wdata;
   logic [31:0] int_rdata;

   int tests = 0;
   int fails = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   logic [31:0] mem  [0:63];
   logic [31:0] prph [0:15];

   always #4 clk = ~clk;  // 125 MHz

   iaw_window u_iaw_window (
      .clk(clk), .rst_n(rst_n), .acc_grant(acc_grant), .host_addr(host_addr),
      .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid), .acc_err(acc_err),
      .int_req(int_req), .int_we(int_we), .int_sel_prph(int_sel_prph),
      .int_addr(int_addr), .int_be(int_be), .int_wdata(int_wdata),
      .int_rdata(int_rdata));

   // Internal memory and peripheral model
   assign int_rdata = int_sel_prph ? prph[int_addr[3:0]] : mem[int_addr[7:2]];
   always @(posedge clk) begin
      if (int_req && int_we) begin
         if (int_sel_prph) begin
            for (int b = 0; b < 4; b++)
               if (int_be[b]) prph[int_addr[3:0]][8*b +: 8] <= int_wdata[8*b +: 8];
         end else begin
            mem[int_addr[7:2]] <= int_wdata;
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected read results as they appear
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) chk("R5 unexpected rvalid", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
   end

   task automatic step();
      @(negedge clk);
      host_wr = 1'b0;
      host_rd = 1'b0;
   endtask

   task automatic hwr(logic [11:0] a, logic [31:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1; #1;
   endtask

   task automatic hrd(logic [11:0] a, logic [31:0] exp, string tag);
      host_addr = a; host_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag); #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | i;
      for (int i = 0; i < 16; i++) prph[i] = 32'h5000_0000 | i;
      prph[5] = 32'hDEAD_BEEF;
      prph[6] = 32'hAABB_CCDD;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 rvalid", {31'd0, host_rvalid}, 32'd0);
      chk("R1 err", {31'd0, acc_err}, 32'd0);
      chk("R1 int_req idle", {31'd0, int_req}, 32'd0);
      step();
      hrd(12'h00C, 32'h0, "R1 rptr reset"); step();
      hrd(12'h010, 32'h0, "R1 wptr reset"); step();
      hrd(12'h044, 32'h0, "R1 prph waddr reset"); step();
      step();
      chk("R5 rvalid low when idle", {31'd0, host_rvalid}, 32'd0);

      // R2 pointer load/readback
      hwr(12'h010, 32'h0000_0080); step();
      hwr(12'h00C, 32'h0000_0040); step();
      hrd(12'h010, 32'h0000_0080, "R2 wptr readback"); step();
      hrd(12'h00C, 32'h0000_0040, "R2 rptr readback"); step();
      hwr(12'h010, 32'hFFFF_FFF0); step();
      hrd(12'h010, 32'hFFFF_FFF0, "R2 wptr full 32 bits"); step();
      hwr(12'h010, 32'h0000_0080); step();

      // R3 streaming memory writes
      for (int i = 0; i < 3; i++) begin
         hwr(12'h018, 32'h11 * (i + 1));
         chk("R3 int_req", {31'd0, int_req}, 32'd1);
         chk("R3 int_we", {31'd0, int_we}, 32'd1);
         chk("R3 int_sel_prph", {31'd0, int_sel_prph}, 32'd0);
         chk("R3 int_addr", int_addr, 32'h80 + 4 * i);
         chk("R3 int_be", {28'd0, int_be}, 32'hF);
         step();
      end
      hrd(12'h010, 32'h0000_008C, "R3 wptr advanced"); step();

      // R4 reads with post-increment
      hrd(12'h01C, 32'hA500_0010, "R4 first read at loaded addr");
      chk("R4 int_addr", int_addr, 32'h40);
      step();
      hrd(12'h01C, 32'hA500_0011, "R4 second read"); step();
      hrd(12'h00C, 32'h0000_0048, "R4 rptr advanced"); step();
      hrd(12'h010, 32'h0000_008C, "R4 wptr independent"); step();
      hwr(12'h00C, 32'h0000_0080); step();
      hrd(12'h01C, 32'h0000_0011, "R4 readback word 0"); step();
      hrd(12'h01C, 32'h0000_0022, "R4 readback word 1"); step();
      hrd(12'h01C, 32'h0000_0033, "R4 readback word 2"); step();

      // R6 peripheral address registers
      hwr(12'h044, 32'hFFFF_1234); step();
      hrd(12'h044, 32'h0300_1234, "R6 prph waddr field mask"); step();
      hwr(12'h048, 32'h0100_0005); step();
      hrd(12'h050, 32'h0000_BEEF, "R7 prph read size1");
      chk("R6 sel_prph", {31'd0, int_sel_prph}, 32'd1);
      chk("R6 prph addr", int_addr, 32'h5);
      chk("R7 read be size1", {28'd0, int_be}, 32'h3);
      step();
      hrd(12'h050, 32'h0000_BEEF, "R6 prph read no increment");
      chk("R6 prph addr held", int_addr, 32'h5);
      step();

      // R7 peripheral byte enables
      hwr(12'h044, 32'h0000_0006); step();
      hwr(12'h04C, 32'h1234_5678);
      chk("R7 be size0", {28'd0, int_be}, 32'h1);
      step();
      hwr(12'h048, 32'h0300_0006); step();
      hrd(12'h050, 32'hAABB_CC78, "R7 size0 write kept upper bytes"); step();
      hwr(12'h044, 32'h0200_0006); step();
      hwr(12'h04C, 32'h9988_7766);
      chk("R7 be size2", {28'd0, int_be}, 32'h7);
      step();
      hrd(12'h050, 32'hAA88_7766, "R7 size2 write"); step();

      // R9 unmapped offsets
      hrd(12'h100, 32'h0, "R9 unmapped read"); step();
      hwr(12'h014, 32'h0000_0200); step();
      hrd(12'h010, 32'h0000_008C, "R9 unmapped write no effect"); step();
      chk("R9 no err", {31'd0, acc_err}, 32'd0);

      // R8 access without grant
      acc_grant = 1'b0;
      hrd(12'h01C, 32'hFFFF_FFFF, "R8 denied read");
      chk("R8 no int_req on read", {31'd0, int_req}, 32'd0);
      step();
      hwr(12'h018, 32'hBAD0_BAD0);
      chk("R8 no int_req on write", {31'd0, int_req}, 32'd0);
      step();
      hwr(12'h010, 32'h0000_0200); step();
      acc_grant = 1'b1;
      hrd(12'h010, 32'h0000_008C, "R8 denied write ignored"); step();
      hwr(12'h00C, 32'h0000_008C); step();
      hrd(12'h01C, 32'hA500_0023, "R8 denied data write ignored"); step();
      chk("R8 err set", {31'd0, acc_err}, 32'd1);
      repeat (3) step();
      chk("R8 err sticky", {31'd0, acc_err}, 32'd1);

      repeat (2) step();
      chk("R5 all reads answered", exp_q.size(), 32'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule